// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block keeps a table of buffer descriptors in its own storage and steps a transmit DMA engine and a receive DMA engine through them. Each descriptor is a pair of 32-bit words: a status word carrying the length, the ownership bit and the per-descriptor options, and a pointer word giving the buffer address. Software fills descriptors through a simple register-bus slave. The sequencer offers the descriptor at the current ring index to the DMA engine when its ownership bit is set. When the engine reports completion, the sequencer hands the descriptor back by clearing that bit, writes the result into the status word, optionally raises an interrupt pulse, and moves to the next index.

Transmit and receive share one descriptor table. A programmable count gives the first entries to the transmit ring and the rest to the receive ring. Each ring closes either at a descriptor whose wrap flag is set or at its last entry. The sequencer never skips a descriptor: it waits at the current index until software sets that descriptor's ownership bit.

Top module: `bdr_ring_seq`

## Requirements
- R1: After reset the transmit index is 0, the receive index equals the reset transmit count (NUM_BD/2, 64 by default), both valid outputs are low, and the count register reads that reset value.
- R2: The bus slave accepts a request when `bus_req` is high and no write-back is in progress, and raises `bus_ack` for exactly one cycle on the next cycle. Word address 0x200 + 2*n is the status word of descriptor n and 0x200 + 2*n + 1 is its pointer word. A write followed by a read of the same word returns the written value in `bus_rdata` during the ack cycle.
- R3: A channel's valid output is high exactly when the descriptor at its current index has status bit 15 set. It then presents status [31:16] as the length and the pointer word as the address. Transmit also presents bit 12 as pad, bit 11 as CRC and bit 9 as the pause-frame marker. When bit 15 is clear, valid stays low even if a later descriptor is ready.
- R4: On a completion accepted with valid high, the status word is rewritten with bit 15 cleared, bits [14:8] kept and bits [7:0] replaced by the completion code. Transmit keeps the length field. Receive replaces the length field with the reported frame length.
- R5: The status-written pulse is high for exactly the one cycle after an accepted completion. The interrupt pulse rises in that same cycle only if status bit 14 of the completed descriptor was set.
- R6: After a completion the index moves to index+1. If status bit 13 (wrap) of the completed descriptor was set, it returns to the ring's first index instead.
- R7: Completing the last descriptor of a ring (first index + count − 1) returns the index to the first index even without the wrap flag.
- R8: Control word address 0 holds the transmit-descriptor count. Writes above NUM_BD store NUM_BD. The receive ring starts at the stored count. A write sets the transmit index to 0 and the receive index to the new count.
- R9: A ring with no descriptors (count 0 for transmit, count NUM_BD for receive) never raises valid.
- R10: A completion strobe while valid is low has no effect: no write-back, no pulse, no index change.
- R11: A bus request that arrives in the same cycle as a write-back is held off and acknowledged one cycle later than usual.
- R12: Control addresses other than 0 and descriptor addresses beyond 2*NUM_BD words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, held until ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| tx_valid | output | 1 | Transmit descriptor ready at current index |
| tx_len | output | 16 | Transmit frame length |
| tx_ptr | output | 32 | Transmit buffer pointer |
| tx_pad | output | 1 | Pad request |
| tx_crc | output | 1 | CRC append request |
| tx_pause | output | 1 | Frame is a pause control frame |
| tx_done | input | 1 | Transmit completion strobe |
| tx_code | input | 8 | Transmit completion code |
| tx_index | output | 8 | Current transmit ring index |
| tx_wr_pulse | output | 1 | Transmit status written |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_valid | output | 1 | Receive descriptor empty at current index |
| rx_buf_len | output | 16 | Receive buffer length field |
| rx_ptr | output | 32 | Receive buffer pointer |
| rx_done | input | 1 | Receive completion strobe |
| rx_frame_len | input | 16 | Received frame length |
| rx_code | input | 8 | Receive completion code |
| rx_index | output | 8 | Current receive ring index |
| rx_wr_pulse | output | 1 | Receive status written |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench parks the transmit index on a descriptor that is not owned while a later one is ready. A sequencer that skipped ahead would raise valid or move the index there. It fires completions with the wrap flag clear at the final entry of a shrunken ring, where a design that trusted only the wrap flag would walk into the receive ring. It also fires them with the wrap flag set mid-ring, where a design that ignored the flag would keep counting. A bus read is issued in the same cycle as a write-back: a slave without hold-off would ack one cycle early. Count writes of 0 and of an oversize value check that an empty ring stays silent and that the receive ring moves its base along with the count.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
   // status word bit positions
   localparam int ST_OWN   = 15;
   localparam int ST_IRQ   = 14;
   localparam int ST_WRAP  = 13;
   localparam int ST_PAD   = 12;
   localparam int ST_CRC   = 11;
   localparam int ST_PAUSE = 9;
   localparam int WORD_W   = 32;

   typedef enum logic {CH_TX = 1'b0, CH_RX = 1'b1} chan_e;
endpackage

// File: rtl/bdr_desc_mem.sv
module bdr_desc_mem
   import bdr_pkg::*;
#(
   parameter int NUM_BD = 128,
   localparam int IDX_W = $clog2(NUM_BD)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_we,
   input  logic [IDX_W-1:0]              bus_idx,
   input  logic                          bus_sel,
   input  logic [WORD_W-1:0]             bus_wdata,
   output logic [WORD_W-1:0]             bus_rdata,
   input  logic [1:0]                    hw_we,
   input  logic [1:0][IDX_W-1:0]         hw_idx,
   input  logic [1:0][WORD_W-1:0]        hw_wdata,
   output logic [1:0][WORD_W-1:0]        rd_stat,
   output logic [1:0][WORD_W-1:0]        rd_ptr
);
   logic [WORD_W-1:0] stat_q [NUM_BD];
   logic [WORD_W-1:0] ptr_q  [NUM_BD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BD; i++) begin
            stat_q[i] <= '0;
            ptr_q[i]  <= '0;
         end
      end else begin
         if (bus_we) begin
            if (bus_sel) ptr_q[bus_idx]  <= bus_wdata;
            else         stat_q[bus_idx] <= bus_wdata;
         end
         for (int c = 0; c < 2; c++) begin
            if (hw_we[c]) stat_q[hw_idx[c]] <= hw_wdata[c];
         end
      end
   end

   assign bus_rdata = bus_sel ? ptr_q[bus_idx] : stat_q[bus_idx];

   for (genvar g = 0; g < 2; g++) begin : g_rd
      assign rd_stat[g] = stat_q[hw_idx[g]];
      assign rd_ptr[g]  = ptr_q[hw_idx[g]];
   end
endmodule

// File: rtl/bdr_bus_slave.sv
module bdr_bus_slave
   import bdr_pkg::*;
#(
   parameter int NUM_BD = 128,
   parameter int ADDR_W = 10,
   localparam int IDX_W = $clog2(NUM_BD),
   localparam int CNT_W = IDX_W + 1,
   localparam int OFF_W = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              bus_ack,
   input  logic              hold,
   output logic              mem_we,
   output logic [IDX_W-1:0]  mem_idx,
   output logic              mem_sel,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic [CNT_W-1:0]  txnum,
   output logic [CNT_W-1:0]  txnum_nxt,
   output logic              restart
);
   localparam logic [CNT_W-1:0] TXNUM_RST = CNT_W'(NUM_BD / 2);
   localparam logic [CNT_W-1:0] TXNUM_MAX = CNT_W'(NUM_BD);

   logic              in_desc, desc_ok, ctrl0, accept;
   logic [OFF_W-1:0]  off;

   assign in_desc = bus_addr[ADDR_W-1];
   assign off     = bus_addr[OFF_W-1:0];
   assign desc_ok = in_desc && (int'(off) < 2 * NUM_BD);
   assign ctrl0   = !in_desc && (off == '0);
   assign accept  = bus_req && !bus_ack && !hold;

   assign mem_idx = off[IDX_W:1];
   assign mem_sel = off[0];
   assign mem_we  = accept && bus_we && desc_ok;
   assign restart = accept && bus_we && ctrl0;
   assign txnum_nxt = (bus_wdata > WORD_W'(NUM_BD)) ? TXNUM_MAX : bus_wdata[CNT_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         txnum     <= TXNUM_RST;
      end else begin
         bus_ack <= accept;
         if (restart) txnum <= txnum_nxt;
         if (accept && !bus_we) begin
            if (desc_ok)    bus_rdata <= mem_rdata;
            else if (ctrl0) bus_rdata <= WORD_W'(txnum);
            else            bus_rdata <= '0;
         end
      end
   end
endmodule

// File: rtl/bdr_ring_chan.sv
module bdr_ring_chan
   import bdr_pkg::*;
#(
   parameter int    NUM_BD   = 128,
   parameter chan_e KIND     = CH_TX,
   parameter int    RST_BASE = 0,
   localparam int   CNT_W    = $clog2(NUM_BD) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  base,
   input  logic [CNT_W-1:0]  count,
   input  logic              restart,
   input  logic [CNT_W-1:0]  restart_base,
   input  logic [WORD_W-1:0] stat,
   input  logic              done,
   input  logic [15:0]       done_len,
   input  logic [7:0]        done_code,
   output logic [CNT_W-1:0]  cur,
   output logic              valid,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_data,
   output logic              wr_pulse,
   output logic              irq
);
   logic             last;
   logic [15:0]      len_out;
   logic [CNT_W-1:0] nxt;

   assign valid   = (count != '0) && stat[ST_OWN];
   assign wr_en   = done && valid;
   assign last    = (cur == base + count - 1'b1);
   assign nxt     = (stat[ST_WRAP] || last) ? base : cur + 1'b1;
   assign len_out = (KIND == CH_RX) ? done_len : stat[31:16];
   assign wr_data = {len_out, 1'b0, stat[14:8], done_code};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur      <= CNT_W'(RST_BASE);
         wr_pulse <= 1'b0;
         irq      <= 1'b0;
      end else begin
         wr_pulse <= wr_en;
         irq      <= wr_en && stat[ST_IRQ];
         if (restart)    cur <= restart_base;
         else if (wr_en) cur <= nxt;
      end
   end
endmodule

// File: rtl/bdr_ring_seq.sv
module bdr_ring_seq
   import bdr_pkg::*;
#(
   parameter int NUM_BD = 128,
   parameter int ADDR_W = 10,
   localparam int IDX_W = $clog2(NUM_BD),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ack,
   output logic              tx_valid,
   output logic [15:0]       tx_len,
   output logic [31:0]       tx_ptr,
   output logic              tx_pad,
   output logic              tx_crc,
   output logic              tx_pause,
   input  logic              tx_done,
   input  logic [7:0]        tx_code,
   output logic [CNT_W-1:0]  tx_index,
   output logic              tx_wr_pulse,
   output logic              tx_irq,
   output logic              rx_valid,
   output logic [15:0]       rx_buf_len,
   output logic [31:0]       rx_ptr,
   input  logic              rx_done,
   input  logic [15:0]       rx_frame_len,
   input  logic [7:0]        rx_code,
   output logic [CNT_W-1:0]  rx_index,
   output logic              rx_wr_pulse,
   output logic              rx_irq
);
   if (NUM_BD < 2 || (1 << IDX_W) != NUM_BD) begin : g_bad_num
      $error("NUM_BD must be a power of two of at least 2");
   end
   if (2 * NUM_BD > (1 << (ADDR_W - 1))) begin : g_bad_addr
      $error("descriptor table does not fit the address space");
   end

   logic                    mem_we, mem_sel, restart;
   logic [IDX_W-1:0]        mem_idx;
   logic [WORD_W-1:0]       mem_rdata;
   logic [CNT_W-1:0]        txnum, txnum_nxt;
   logic [1:0][CNT_W-1:0]   base, count, rbase, cur;
   logic [1:0][IDX_W-1:0]   rd_idx;
   logic [1:0][WORD_W-1:0]  stat_w, ptr_w, wr_data;
   logic [1:0][15:0]        dlen;
   logic [1:0][7:0]         dcode;
   logic [1:0]              done, valid, wr_en, pulse, irq;

   bdr_bus_slave #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W)) u_slave (
      .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_rdata, .bus_ack,
      .hold(|wr_en), .mem_we, .mem_idx, .mem_sel, .mem_rdata,
      .txnum, .txnum_nxt, .restart
   );

   bdr_desc_mem #(.NUM_BD(NUM_BD)) u_mem (
      .clk, .rst_n, .bus_we(mem_we), .bus_idx(mem_idx), .bus_sel(mem_sel),
      .bus_wdata, .bus_rdata(mem_rdata), .hw_we(wr_en), .hw_idx(rd_idx),
      .hw_wdata(wr_data), .rd_stat(stat_w), .rd_ptr(ptr_w)
   );

   assign base[0]  = '0;
   assign count[0] = txnum;
   assign rbase[0] = '0;
   assign base[1]  = txnum;
   assign count[1] = CNT_W'(NUM_BD) - txnum;
   assign rbase[1] = txnum_nxt;
   assign done     = {rx_done, tx_done};
   assign dlen     = {rx_frame_len, 16'h0000};
   assign dcode    = {rx_code, tx_code};

   for (genvar g = 0; g < 2; g++) begin : g_chan
      assign rd_idx[g] = cur[g][IDX_W-1:0];
      bdr_ring_chan #(
         .NUM_BD(NUM_BD), .KIND(chan_e'(g)), .RST_BASE(g * (NUM_BD / 2))
      ) u_chan (
         .clk, .rst_n, .base(base[g]), .count(count[g]), .restart,
         .restart_base(rbase[g]), .stat(stat_w[g]), .done(done[g]),
         .done_len(dlen[g]), .done_code(dcode[g]), .cur(cur[g]),
         .valid(valid[g]), .wr_en(wr_en[g]), .wr_data(wr_data[g]),
         .wr_pulse(pulse[g]), .irq(irq[g])
      );
   end

   assign tx_valid    = valid[0];
   assign tx_len      = stat_w[0][31:16];
   assign tx_ptr      = ptr_w[0];
   assign tx_pad      = stat_w[0][ST_PAD];
   assign tx_crc      = stat_w[0][ST_CRC];
   assign tx_pause    = stat_w[0][ST_PAUSE];
   assign tx_index    = cur[0];
   assign tx_wr_pulse = pulse[0];
   assign tx_irq      = irq[0];
   assign rx_valid    = valid[1];
   assign rx_buf_len  = stat_w[1][31:16];
   assign rx_ptr      = ptr_w[1];
   assign rx_index    = cur[1];
   assign rx_wr_pulse = pulse[1];
   assign rx_irq      = irq[1];
endmodule

// File: rtl/bdr_ring_seq_chk.sv
module bdr_ring_seq_chk #(
   parameter int NUM_BD = 128,
   localparam int CNT_W = $clog2(NUM_BD) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_req,
   input logic             bus_ack,
   input logic             tx_done,
   input logic             tx_valid,
   input logic             tx_wr_pulse,
   input logic             tx_irq,
   input logic [CNT_W-1:0] tx_index,
   input logic             rx_done,
   input logic             rx_valid,
   input logic             rx_wr_pulse,
   input logic             rx_irq,
   input logic [CNT_W-1:0] txnum
);
   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack); // R2
   AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |-> $past(bus_req)); // R2
   AST_TX_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr_pulse |-> $past(tx_done && tx_valid)); // R5
   AST_RX_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_wr_pulse |-> $past(rx_done && rx_valid)); // R5
   AST_TX_IRQ_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> tx_wr_pulse); // R5
   AST_RX_IRQ_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_wr_pulse); // R5
   AST_TX_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tx_done) && !bus_ack) |-> $stable(tx_index)); // R6
   AST_TX_EMPTY_RING: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (txnum != '0)); // R9
   AST_RX_EMPTY_RING: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (int'(txnum) < NUM_BD)); // R9
endmodule

bind bdr_ring_seq bdr_ring_seq_chk #(.NUM_BD(NUM_BD)) u_chk (.*);

// File: tb/tb_bdr_ring_seq.sv
module tb_bdr_ring_seq;
   localparam int NUM_BD = 128;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_req = 1'b0, bus_we = 1'b0;
   logic [9:0]        bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              bus_ack;
   logic              tx_valid, tx_pad, tx_crc, tx_pause, tx_wr_pulse, tx_irq;
   logic [15:0]       tx_len;
   logic [31:0]       tx_ptr;
   logic              tx_done = 1'b0;
   logic [7:0]        tx_code = '0;
   logic [CNT_W-1:0]  tx_index, rx_index;
   logic              rx_valid, rx_wr_pulse, rx_irq;
   logic [15:0]       rx_buf_len;
   logic [31:0]       rx_ptr;
   logic              rx_done = 1'b0;
   logic [15:0]       rx_frame_len = '0;
   logic [7:0]        rx_code = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bdr_ring_seq #(.NUM_BD(NUM_BD)) dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      do @(negedge clk); while (!bus_ack);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      do @(negedge clk); while (!bus_ack);
      d = bus_rdata;
      bus_req = 1'b0;
   endtask

   // one tx completion; returns at the negedge after the accepting edge
   task automatic tx_fire(input logic [7:0] code);
      @(negedge clk);
      tx_done = 1'b1; tx_code = code;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 tx_index", 32'(tx_index), 0);
      chk("R1 rx_index", 32'(rx_index), 64);
      chk("R1 tx_valid", 32'(tx_valid), 0);
      chk("R1 rx_valid", 32'(rx_valid), 0);
      bus_rd(10'h000, d);
      chk("R1 count reg", d, 64);
   endtask

   task automatic t_bus();
      logic [31:0] d;
      bus_wr(10'h207, 32'hDEAD_BEE0);
      bus_rd(10'h207, d);
      chk("R2 pointer word round trip", d, 32'hDEAD_BEE0);
      bus_wr(10'h005, 32'h1234);
      bus_rd(10'h005, d);
      chk("R12 unused control reads 0", d, 0);
      bus_wr(10'h300, 32'hFFFF_FFFF);
      bus_rd(10'h300, d);
      chk("R12 out-of-range descriptor reads 0", d, 0);
      bus_rd(10'h000, d);
      chk("R12 count unchanged", d, 64);
   endtask

   task automatic t_present();
      bus_wr(10'h201, 32'h0000_1000);
      bus_wr(10'h200, 32'h0040_9A00);
      bus_wr(10'h204, 32'h0020_8000);
      chk("R3 tx_valid", 32'(tx_valid), 1);
      chk("R3 tx_len", 32'(tx_len), 32'h40);
      chk("R3 tx_ptr", tx_ptr, 32'h1000);
      chk("R3 pad/crc/pause", {29'd0, tx_pad, tx_crc, tx_pause}, 3'b111);
   endtask

   task automatic t_complete();
      logic [31:0] d;
      tx_fire(8'hA5);
      chk("R5 wr pulse", 32'(tx_wr_pulse), 1);
      chk("R5 no irq without bit14", 32'(tx_irq), 0);
      chk("R6 index advance", 32'(tx_index), 1);
      @(negedge clk);
      chk("R5 pulse one cycle", 32'(tx_wr_pulse), 0);
      bus_rd(10'h200, d);
      chk("R4 tx status write-back", d, 32'h0040_1AA5);
   endtask

   task automatic t_stall();
      logic [31:0] d;
      chk("R3 stall on not-ready", 32'(tx_valid), 0);
      tx_fire(8'h77);
      chk("R10 no pulse", 32'(tx_wr_pulse), 0);
      chk("R10 index kept", 32'(tx_index), 1);
      bus_rd(10'h204, d);
      chk("R10 later descriptor untouched", d, 32'h0020_8000);
   endtask

   task automatic t_irq_wrap();
      bus_wr(10'h202, 32'h0010_E000);
      chk("R3 valid after set", 32'(tx_valid), 1);
      tx_fire(8'h00);
      chk("R5 irq with bit14", 32'(tx_irq), 1);
      chk("R6 wrap to base", 32'(tx_index), 0);
   endtask

   task automatic t_rx();
      logic [31:0] d;
      bus_wr(10'h281, 32'h0000_8000);
      bus_wr(10'h280, 32'h0600_C000);
      chk("R3 rx_valid", 32'(rx_valid), 1);
      chk("R3 rx_ptr", rx_ptr, 32'h8000);
      chk("R3 rx_buf_len", 32'(rx_buf_len), 32'h600);
      @(negedge clk);
      rx_done = 1'b1; rx_frame_len = 16'h003C; rx_code = 8'h11;
      @(negedge clk);
      rx_done = 1'b0;
      chk("R5 rx irq", 32'(rx_irq), 1);
      chk("R5 rx pulse", 32'(rx_wr_pulse), 1);
      chk("R6 rx index", 32'(rx_index), 65);
      bus_rd(10'h280, d);
      chk("R4 rx status write-back", d, 32'h003C_4011);
   endtask

   task automatic t_holdoff();
      bus_wr(10'h200, 32'h0008_8000);
      @(negedge clk);
      tx_done = 1'b1; tx_code = 8'h01;
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = 10'h000;
      @(negedge clk);
      tx_done = 1'b0;
      chk("R11 ack held off", 32'(bus_ack), 0);
      chk("R11 write-back happened", 32'(tx_wr_pulse), 1);
      @(negedge clk);
      chk("R11 delayed ack", 32'(bus_ack), 1);
      chk("R11 read data", bus_rdata, 64);
      bus_req = 1'b0;
   endtask

   task automatic t_ring_end();
      bus_wr(10'h000, 32'd2);
      chk("R8 tx index restart", 32'(tx_index), 0);
      chk("R8 rx index at count", 32'(rx_index), 2);
      chk("R8 rx sees shared desc 2", 32'(rx_valid), 1);
      chk("R8 rx len of desc 2", 32'(rx_buf_len), 32'h20);
      bus_wr(10'h200, 32'h0001_8000);
      bus_wr(10'h202, 32'h0001_8000);
      tx_fire(8'h02);
      chk("R6 step to 1", 32'(tx_index), 1);
      tx_fire(8'h03);
      chk("R7 last entry returns to 0", 32'(tx_index), 0);
   endtask

   task automatic t_clamp();
      logic [31:0] d;
      bus_wr(10'h000, 32'h3FF);
      bus_rd(10'h000, d);
      chk("R8 count clamped", d, NUM_BD);
      chk("R9 empty rx ring", 32'(rx_valid), 0);
      bus_wr(10'h200, 32'h0001_8000);
      chk("R9 full tx ring valid", 32'(tx_valid), 1);
      bus_wr(10'h000, 32'd0);
      chk("R9 empty tx ring", 32'(tx_valid), 0);
      chk("R8 rx index 0", 32'(rx_index), 0);
      chk("R8 rx owns desc 0", 32'(rx_valid), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bus();
      t_present();
      t_complete();
      t_stall();
      t_irq_wrap();
      t_rx();
      t_holdoff();
      t_ring_end();
      t_clamp();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule